// File: doc/BRIEF.md
# Exception Vector and Mode Controller

This block belongs to a processor's exception unit. It keeps three status items: an exception-level flag, a boot-vector select flag and a two-bit privilege-mode field. When the pipeline raises an exception, the block uses the exception class and the status as it stood in that cycle to choose the handler fetch address. One cycle later it presents that address on a 64-bit redirect output together with a one-cycle valid strobe.

The three status items change in four ways: a taken exception, an exception-return pulse, software write ports and cold reset. The 64-bit redirect address carries ones or zeros in its upper half, as a mode input selects. Saving the victim PC, cause encoding, TLB handling and caches all live outside this block.

Top module: `exc_vector_ctrl`

## Requirements
- R1: A cycle with `exc_req_i` high sets `exl_o` to 1 in the next cycle, and a software write of 0 to the flag in that same cycle has no effect.
- R2: An `eret_i` pulse with no exception request clears `exl_o` to 0 in the next cycle, and it overrides a software flag write in the same cycle.
- R3: When `exc_req_i` and `eret_i` are both high, the exception wins: `exl_o` is 1 and `redir_valid_o` pulses in the next cycle.
- R4: Class codes 0 (cold reset), 1 (soft reset) and 2 (NMI) redirect to low word 0xBFC00000 whatever the value of `bev_o`.
- R5: With `bev_o`=0 and `exl_o`=0 at the request, the low word of the redirect address is one of four values: 0x80000000 for class 3 (TLB refill), 0x80000080 for class 4 (extended refill), 0xA0000100 for class 5 (cache error) and 0x80000180 for classes 6 and 7 (other).
- R6: With `bev_o`=1, the same classes map to 0xBFC00200, 0xBFC00280, 0xBFC00300 and 0xBFC00380 respectively.
- R7: A class 3 or class 4 request made while `exl_o`=1 uses the "other" vector for the current `bev_o` value.
- R8: The upper 32 address bits are 0xFFFFFFFF when `addr64_i` was high at the request and zero otherwise.
- R9: `redir_valid_o` is high for exactly the one cycle after each request. `redir_addr_o` changes only at that point and holds its value otherwise.
- R10: While `rst_ni` is low, the outputs are `exl_o`=1, `bev_o`=1, `mode_o`=00, `redir_valid_o`=0 and `redir_addr_o`=0.
- R11: With no exception or return pending, the write enables `mode_we_i`, `exl_we_i` and `bev_we_i` load their values, which show on the outputs one cycle later.
- R12: A class 0 request forces `bev_o` to 1 and `mode_o` to 00 in the next cycle, and it overrides software writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous cold reset |
| exc_req_i | input | 1 | One-cycle exception request |
| exc_class_i | input | 3 | Exception class code |
| eret_i | input | 1 | Exception-return pulse |
| mode_we_i | input | 1 | Privilege-mode write enable |
| mode_i | input | 2 | Privilege-mode write value |
| exl_we_i | input | 1 | Exception-level flag write enable |
| exl_i | input | 1 | Exception-level flag write value |
| bev_we_i | input | 1 | Boot-vector flag write enable |
| bev_i | input | 1 | Boot-vector flag write value |
| addr64_i | input | 1 | 64-bit addressing mode select |
| redir_addr_o | output | 64 | Handler fetch address |
| redir_valid_o | output | 1 | Redirect strobe, one cycle per request |
| exl_o | output | 1 | Exception-level flag |
| bev_o | output | 1 | Boot-vector select flag |
| mode_o | output | 2 | Privilege-mode field |

## Verification
A wrong status bit stays hidden at first. It shows only when the next exception picks its vector, so an error in the exception-level or boot-vector flag appears as a wrong redirect address one cycle after a later request. The bench makes a request after every status change and also compares the status outputs on every cycle, so an error shows in the cycle after it happens. A wrong precedence between request, return and software write shows up in that same next cycle on `exl_o`, `bev_o` or `mode_o`.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

    typedef enum logic [2:0] {
        EXC_COLD    = 3'd0,
        EXC_SOFT    = 3'd1,
        EXC_NMI     = 3'd2,
        EXC_REFILL  = 3'd3,
        EXC_XREFILL = 3'd4,
        EXC_CERR    = 3'd5,
        EXC_GEN     = 3'd6,
        EXC_GEN_ALT = 3'd7
    } exc_class_e;

    typedef enum logic [1:0] {
        SLOT_REFILL  = 2'd0,
        SLOT_XREFILL = 2'd1,
        SLOT_CERR    = 2'd2,
        SLOT_GEN     = 2'd3
    } vec_slot_e;

    localparam logic [1:0] MODE_KERNEL = 2'b00;

    typedef struct packed {
        logic       exl;
        logic       bev;
        logic [1:0] mode;
    } exc_status_t;

endpackage

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
    import exc_vec_pkg::*;
#(
    parameter int          VEC_W         = 32,
    parameter int          STRIDE_SH     = 7,
    parameter logic [31:0] RESET_VEC     = 32'hBFC0_0000,
    parameter logic [31:0] CACHED_BASE   = 32'h8000_0000,
    parameter logic [31:0] UNCACHED_BASE = 32'hA000_0000,
    parameter logic [31:0] BOOT_BASE     = 32'hBFC0_0200
) (
    input  logic [2:0]       cls_i,
    input  logic             exl_i,
    input  logic             bev_i,
    output logic [VEC_W-1:0] vec_o
);
    localparam int SLOT_W = 2;

    vec_slot_e        slot;
    logic             is_reset;
    logic [VEC_W-1:0] base;
    logic [VEC_W-1:0] offset;

    always_comb begin
        is_reset = (cls_i == EXC_COLD) || (cls_i == EXC_SOFT) || (cls_i == EXC_NMI);
        unique case (cls_i)
            EXC_REFILL:  slot = exl_i ? SLOT_GEN : SLOT_REFILL;
            EXC_XREFILL: slot = exl_i ? SLOT_GEN : SLOT_XREFILL;
            EXC_CERR:    slot = SLOT_CERR;
            default:     slot = SLOT_GEN;
        endcase
        offset = {{(VEC_W-SLOT_W){1'b0}}, slot} << STRIDE_SH;
        if (bev_i) begin
            base = VEC_W'(BOOT_BASE);
        end else if (slot == SLOT_CERR) begin
            base = VEC_W'(UNCACHED_BASE);
        end else begin
            base = VEC_W'(CACHED_BASE);
        end
        vec_o = is_reset ? VEC_W'(RESET_VEC) : (base + offset);
    end

endmodule

// File: rtl/exc_vec_widen.sv
module exc_vec_widen #(
    parameter int IN_W  = 32,
    parameter int OUT_W = 64
) (
    input  logic [IN_W-1:0]  vec_i,
    input  logic             wide_i,
    output logic [OUT_W-1:0] addr_o
);
    localparam int EXT_W = OUT_W - IN_W;

    always_comb begin
        addr_o = {{EXT_W{wide_i}}, vec_i};
    end

endmodule

// File: rtl/exc_status_next.sv
module exc_status_next
    import exc_vec_pkg::*;
(
    input  exc_status_t cur_i,
    input  logic        take_i,
    input  logic        cold_i,
    input  logic        eret_i,
    input  logic        mode_we_i,
    input  logic [1:0]  mode_i,
    input  logic        exl_we_i,
    input  logic        exl_i,
    input  logic        bev_we_i,
    input  logic        bev_i,
    output exc_status_t nxt_o
);
    always_comb begin
        nxt_o = cur_i;
        if (mode_we_i) nxt_o.mode = mode_i;
        if (bev_we_i)  nxt_o.bev  = bev_i;
        if (exl_we_i)  nxt_o.exl  = exl_i;
        if (eret_i)    nxt_o.exl  = 1'b0;
        if (take_i)    nxt_o.exl  = 1'b1;
        if (cold_i) begin
            nxt_o.bev  = 1'b1;
            nxt_o.mode = MODE_KERNEL;
        end
    end

endmodule

// File: rtl/exc_vector_ctrl.sv
module exc_vector_ctrl
    import exc_vec_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int VEC_W  = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              exc_req_i,
    input  logic [2:0]        exc_class_i,
    input  logic              eret_i,
    input  logic              mode_we_i,
    input  logic [1:0]        mode_i,
    input  logic              exl_we_i,
    input  logic              exl_i,
    input  logic              bev_we_i,
    input  logic              bev_i,
    input  logic              addr64_i,
    output logic [ADDR_W-1:0] redir_addr_o,
    output logic              redir_valid_o,
    output logic              exl_o,
    output logic              bev_o,
    output logic [1:0]        mode_o
);
    typedef struct packed {
        exc_status_t       st;
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } ctrl_state_t;

    localparam exc_status_t ST_RESET = '{exl: 1'b1, bev: 1'b1, mode: MODE_KERNEL};

    ctrl_state_t       state_d, state_q;
    logic [VEC_W-1:0]  vec32;
    logic [ADDR_W-1:0] vec_full;
    exc_status_t       st_nxt;
    logic              cold_req;

    assign cold_req = exc_req_i && (exc_class_i == EXC_COLD);

    exc_vec_sel #(.VEC_W(VEC_W)) i_sel (
        .cls_i (exc_class_i),
        .exl_i (state_q.st.exl),
        .bev_i (state_q.st.bev),
        .vec_o (vec32)
    );

    exc_vec_widen #(.IN_W(VEC_W), .OUT_W(ADDR_W)) i_widen (
        .vec_i  (vec32),
        .wide_i (addr64_i),
        .addr_o (vec_full)
    );

    exc_status_next i_next (
        .cur_i     (state_q.st),
        .take_i    (exc_req_i),
        .cold_i    (cold_req),
        .eret_i    (eret_i),
        .mode_we_i (mode_we_i),
        .mode_i    (mode_i),
        .exl_we_i  (exl_we_i),
        .exl_i     (exl_i),
        .bev_we_i  (bev_we_i),
        .bev_i     (bev_i),
        .nxt_o     (st_nxt)
    );

    always_comb begin
        state_d       = state_q;
        state_d.st    = st_nxt;
        state_d.valid = exc_req_i;
        if (exc_req_i) begin
            state_d.addr = vec_full;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q.st    <= ST_RESET;
            state_q.valid <= 1'b0;
            state_q.addr  <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign redir_addr_o  = state_q.addr;
    assign redir_valid_o = state_q.valid;
    assign exl_o         = state_q.st.exl;
    assign bev_o         = state_q.st.bev;
    assign mode_o        = state_q.st.mode;

endmodule

// File: rtl/exc_vector_ctrl_chk.sv
module exc_vector_ctrl_chk #(
    parameter int ADDR_W = 64
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              exc_req_i,
    input logic [2:0]        exc_class_i,
    input logic              eret_i,
    input logic              addr64_i,
    input logic [ADDR_W-1:0] redir_addr_o,
    input logic              redir_valid_o,
    input logic              exl_o,
    input logic              bev_o,
    input logic [1:0]        mode_o
);
    assert_take_sets_exl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_req_i |=> exl_o);

    assert_eret_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eret_i && !exc_req_i) |=> !exl_o);

    assert_exc_beats_eret_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eret_i && exc_req_i) |=> (exl_o && redir_valid_o));

    assert_reset_vector_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_req_i && exc_class_i <= 3'd2) |=> (redir_addr_o[31:0] == 32'hBFC0_0000));

    assert_cerr_uncached_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_req_i && exc_class_i == 3'd5 && !bev_o) |=> (redir_addr_o[31:0] == 32'hA000_0100));

    assert_boot_region_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_req_i && bev_o) |=> (redir_addr_o[31:12] == 20'hBFC00));

    assert_nested_refill_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_req_i && exl_o && (exc_class_i == 3'd3 || exc_class_i == 3'd4))
        |=> (redir_addr_o[8:0] == 9'h180));

    assert_upper_ones_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_req_i && addr64_i) |=> (redir_addr_o[ADDR_W-1:32] == '1));

    assert_upper_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_req_i && !addr64_i) |=> (redir_addr_o[ADDR_W-1:32] == '0));

    assert_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !exc_req_i |=> (!redir_valid_o && $stable(redir_addr_o)));

    assert_reset_state_R10: assert property (@(posedge clk_i)
        !rst_ni |=> (exl_o && bev_o && mode_o == 2'b00 && !redir_valid_o));

    assert_cold_class_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_req_i && exc_class_i == 3'd0) |=> (bev_o && mode_o == 2'b00));

endmodule

bind exc_vector_ctrl exc_vector_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .exc_req_i     (exc_req_i),
    .exc_class_i   (exc_class_i),
    .eret_i        (eret_i),
    .addr64_i      (addr64_i),
    .redir_addr_o  (redir_addr_o),
    .redir_valid_o (redir_valid_o),
    .exl_o         (exl_o),
    .bev_o         (bev_o),
    .mode_o        (mode_o)
);

// File: tb/test_exc_vector_ctrl.sv
`timescale 1ns/1ps
module test_exc_vector_ctrl;
    localparam int ADDR_W = 64;
    localparam int WD_LIMIT = 100000;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic req = 0, eret = 0, mwe = 0, ewe = 0, eval = 0, bwe = 0, bval = 0, a64 = 0;
    logic [2:0] cls = 0;
    logic [1:0] mval = 0;
    logic [ADDR_W-1:0] addr;
    logic valid, exl, bev;
    logic [1:0] mode;

    exc_vector_ctrl #(.ADDR_W(ADDR_W)) i_exc_vector_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .exc_req_i(req), .exc_class_i(cls),
        .eret_i(eret), .mode_we_i(mwe), .mode_i(mval), .exl_we_i(ewe),
        .exl_i(eval), .bev_we_i(bwe), .bev_i(bval), .addr64_i(a64),
        .redir_addr_o(addr), .redir_valid_o(valid), .exl_o(exl),
        .bev_o(bev), .mode_o(mode)
    );

    int checks = 0, errors = 0, cycles = 0;
    string chk_tag = "R10";

    logic m_exl = 1, m_bev = 1, m_valid = 0;
    logic [1:0] m_mode = 0;
    logic [63:0] m_addr = 0;

    function automatic logic [63:0] ref_vec(input logic [2:0] c, input logic b,
                                            input logic e, input logic w);
        logic [31:0] lo;
        case (c)
            3'd0, 3'd1, 3'd2: lo = 32'hBFC0_0000;
            3'd3: lo = e ? (b ? 32'hBFC0_0380 : 32'h8000_0180) : (b ? 32'hBFC0_0200 : 32'h8000_0000);
            3'd4: lo = e ? (b ? 32'hBFC0_0380 : 32'h8000_0180) : (b ? 32'hBFC0_0280 : 32'h8000_0080);
            3'd5: lo = b ? 32'hBFC0_0300 : 32'hA000_0100;
            default: lo = b ? 32'hBFC0_0380 : 32'h8000_0180;
        endcase
        return {w ? 32'hFFFF_FFFF : 32'h0, lo};
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_exl = 1; m_bev = 1; m_mode = 0; m_valid = 0; m_addr = 0;
        end else begin
            m_valid = req;
            if (req) m_addr = ref_vec(cls, m_bev, m_exl, a64);
            if (mwe) m_mode = mval;
            if (bwe) m_bev = bval;
            if (req) m_exl = 1;
            else if (eret) m_exl = 0;
            else if (ewe) m_exl = eval;
            if (req && cls == 3'd0) begin m_bev = 1; m_mode = 0; end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        if (cycles > WD_LIMIT) begin
            errors++;
            $display("FAIL R9 watchdog: actual %0d cycles, expected below %0d", cycles, WD_LIMIT);
            summary();
            $finish;
        end
    end

    task automatic cmp(string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", chk_tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        cmp("redir_valid", 64'(valid), 64'(m_valid));
        cmp("redir_addr", addr, m_addr);
        cmp("exl", 64'(exl), 64'(m_exl));
        cmp("bev", 64'(bev), 64'(m_bev));
        cmp("mode", 64'(mode), 64'(m_mode));
    endtask

    task automatic step(logic r, logic [2:0] c, logic er, logic mw, logic [1:0] mv,
                        logic ew, logic ev, logic bw, logic bv, logic w, string tag);
        @(negedge clk);
        check_all();
        chk_tag = tag;
        req = r; cls = c; eret = er; mwe = mw; mval = mv;
        ewe = ew; eval = ev; bwe = bw; bval = bv; a64 = w;
    endtask

    initial begin
        repeat (3) begin
            @(negedge clk);
            chk_tag = "R10";
            check_all();
        end
        rst_n = 1'b1;
        //   req cls  eret mwe mv   ewe ev  bwe bv  a64
        step(1, 3'd3, 0, 0, 2'd0, 0, 0, 0, 0, 1, "R7");   // refill with flag set, boot
        step(0, 3'd0, 0, 0, 2'd0, 0, 0, 0, 0, 0, "R9");
        step(0, 3'd0, 0, 0, 2'd0, 1, 0, 0, 0, 0, "R11");  // software clears flag
        step(1, 3'd3, 0, 0, 2'd0, 0, 0, 0, 0, 1, "R6");
        step(0, 3'd0, 0, 0, 2'd0, 1, 0, 0, 0, 0, "R11");
        step(1, 3'd4, 0, 0, 2'd0, 0, 0, 0, 0, 0, "R8");   // upper half zero
        step(1, 3'd5, 0, 0, 2'd0, 0, 0, 0, 0, 1, "R6");
        step(1, 3'd6, 0, 0, 2'd0, 0, 0, 0, 0, 0, "R6");
        step(0, 3'd0, 1, 0, 2'd0, 0, 0, 0, 0, 0, "R2");
        step(0, 3'd0, 0, 0, 2'd0, 0, 0, 1, 0, 0, "R11");  // boot flag to 0
        step(1, 3'd3, 0, 0, 2'd0, 0, 0, 0, 0, 1, "R5");
        step(0, 3'd0, 1, 0, 2'd0, 0, 0, 0, 0, 0, "R2");
        step(1, 3'd4, 0, 0, 2'd0, 0, 0, 0, 0, 1, "R5");
        step(0, 3'd0, 1, 0, 2'd0, 0, 0, 0, 0, 0, "R2");
        step(1, 3'd5, 0, 0, 2'd0, 0, 0, 0, 0, 0, "R5");
        step(1, 3'd7, 0, 0, 2'd0, 0, 0, 0, 0, 1, "R5");
        step(0, 3'd0, 0, 0, 2'd1, 0, 0, 0, 0, 0, "R9");
        step(1, 3'd0, 0, 0, 2'd0, 0, 0, 0, 0, 1, "R4");   // bev 0 at request
        step(1, 3'd1, 0, 0, 2'd0, 0, 0, 0, 0, 0, "R4");
        step(0, 3'd0, 0, 0, 2'd0, 1, 0, 1, 0, 0, "R11");
        step(1, 3'd2, 0, 0, 2'd0, 0, 0, 0, 0, 1, "R4");
        step(1, 3'd3, 0, 0, 2'd0, 0, 0, 0, 0, 1, "R7");   // flag set, bev 0
        step(1, 3'd6, 1, 0, 2'd0, 0, 0, 0, 0, 0, "R3");
        step(0, 3'd0, 0, 1, 2'd2, 0, 0, 0, 0, 0, "R11");
        step(1, 3'd0, 0, 1, 2'd3, 0, 0, 1, 0, 1, "R12");
        step(0, 3'd0, 1, 0, 2'd0, 1, 1, 0, 0, 0, "R2");
        step(1, 3'd6, 0, 0, 2'd0, 1, 0, 0, 0, 0, "R1");
        for (int i = 0; i < 400; i++) begin
            step($urandom_range(0, 2) == 0, 3'($urandom), $urandom_range(0, 3) == 0,
                 $urandom_range(0, 3) == 0, 2'($urandom), $urandom_range(0, 2) == 0,
                 1'($urandom), $urandom_range(0, 4) == 0, 1'($urandom), 1'($urandom), "R9");
        end
        step(0, 3'd0, 0, 0, 2'd0, 0, 0, 0, 0, 0, "R9");
        step(0, 3'd0, 0, 0, 2'd0, 0, 0, 0, 0, 0, "R9");
        summary();
        $finish;
    end

endmodule